// File: doc/BRIEF.md
# Tensor Micro-Op Expansion Sequencer

This block turns a single matrix multiply-accumulate macro instruction into a fixed stream of 32 tensor micro-ops. The issue logic in front of it raises `mac_valid`. The sequencer accepts the macro in a cycle when it is idle. It then walks a counter through four operand sets. Each set has four steps, and each step has two halves. For every position the block presents one micro-op on a valid/ready output port.

The block works out each micro-op's fields from the counter. It does not read them from a decoded instruction. The fields are the execution type, the operation code, the modifier, the flags, the PC and immediate words, and four register indices. The accumulator register is read and written in place. The final micro-op is tagged as the finish. It carries a next-position index of zero, and it returns the sequencer to idle. A one-cycle done pulse marks the handshake of that final micro-op.

Register indices are `REG_W` bits wide. Float register `n` is encoded as `FREG_BASE + n`, which is 32 + n by default.

Top module: `tmma_uop_seq`

## Requirements
- R1: A synchronous active-low reset, applied at any time, leaves the block idle. While idle, `mac_ready`=1, `uop_valid`=0 and `seq_done`=0, and the next accepted macro starts at position 0.
- R2: An accepted macro produces exactly 32 micro-ops. Position k = 8*set + 2*step + half runs from 0 to 31, so half changes fastest and set slowest. `uop_seq` shows k. `uop_next` shows (k+1) mod 32.
- R3: Every micro-op has `uop_ex` equal to `EX_TENSOR` (default 5), `uop_op` equal to step, and `uop_mod` equal to half.
- R4: `uop_rd` is float register 16 + 2*step + half. `uop_rs3` equals `uop_rd`.
- R5: `uop_rs1` is float register 2*set + half. `uop_rs2` is float register 8 + 2*set + half.
- R6: Every micro-op has `uop_wb`=1, `uop_use_pc`=0 and `uop_use_imm`=0.
- R7: `uop_last` (the finish tag) is 1 only at position 31. `uop_pc` and `uop_imm` are 0 at positions 0 to 30 and 1 at position 31.
- R8: While `uop_valid`=1 and `uop_ready`=0, the position and all micro-op fields hold steady into the next cycle.
- R9: `seq_done` is 1 in exactly the cycle in which position 31 is handshaken. While a macro is running, `mac_ready`=0 and `mac_valid` has no effect on the stream.
- R10: The cycle after `seq_done`, the block is idle again. A new macro can then be accepted and starts over from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mac_valid | input | 1 | Macro instruction offered |
| mac_ready | output | 1 | Sequencer idle, so a macro is accepted |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Downstream takes the micro-op |
| uop_seq | output | IDX_W (5) | Current position k |
| uop_next | output | IDX_W (5) | Following position, wrapping to 0 |
| uop_last | output | 1 | Finish tag |
| uop_ex | output | EX_W (3) | Execution type |
| uop_op | output | OP_W (4) | Operation code (step) |
| uop_mod | output | MOD_W (3) | Modifier (half) |
| uop_wb | output | 1 | Writeback enable |
| uop_use_pc | output | 1 | PC operand select |
| uop_use_imm | output | 1 | Immediate operand select |
| uop_pc | output | DATA_W (32) | PC field |
| uop_imm | output | DATA_W (32) | Immediate field |
| uop_rd | output | REG_W (6) | Destination register |
| uop_rs1 | output | REG_W (6) | First source register |
| uop_rs2 | output | REG_W (6) | Second source register |
| uop_rs3 | output | REG_W (6) | Third source (accumulator) register |
| seq_done | output | 1 | Pulse with the finish handshake |

## Verification
The hardest cases to reach from the ports are the ones where a stall, a reset or a competing macro falls in the middle of a stream. Examples are a stall that lands on the final micro-op, a reset that arrives partway through, and a new macro offered while the old one runs.

The bench sweeps all 32 positions under several `uop_ready` patterns, including patterns that stall on position 31. It holds `mac_valid` high for a whole stream and then issues macros back to back. It also resets in the middle of a stream. At every one of these points it compares each field against the position arithmetic.

// File: rtl/tmma_pkg.sv
// Package: shared types for the tensor micro-op sequencer.
// Assumes: included ahead of all sequencer modules.
package tmma_pkg;

    // Sequencer control state
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Per-micro-op control flags
    typedef struct packed {
        logic wb;
        logic use_pc;
        logic use_imm;
    } uop_flags_t;

endpackage

// File: rtl/tmma_uop_counter.sv
// Module: position counter over set/step/half.
// The half bit is the LSB, then the step, then the set, so a plain
// increment walks the required order. The counter wraps to zero after
// the final position.
// Assumes: clear and advance are never asserted together.
module tmma_uop_counter #(
    parameter int unsigned SET_W  = 2,
    parameter int unsigned STEP_W = 2,
    localparam int unsigned IDX_W = SET_W + STEP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [SET_W-1:0]  set_o,
    output logic [STEP_W-1:0] step_o,
    output logic              half_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [IDX_W-1:0]  next_o,
    output logic              last_o
);

    logic [IDX_W-1:0] idx_q;

    // Position register: reset/clear to zero, step on each handshake
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Field slicing and following-position decode
    always_comb begin
        half_o = idx_q[0];
        step_o = idx_q[STEP_W:1];
        set_o  = idx_q[IDX_W-1:STEP_W+1];
        idx_o  = idx_q;
        next_o = idx_q + 1'b1;
        last_o = &idx_q;
    end

endmodule

// File: rtl/tmma_uop_fields.sv
// Module: combinational micro-op field generator.
// Builds every field of one micro-op from the set, step and half of the
// current position.
// Assumes: register indices fit in REG_W bits for the chosen bases.
module tmma_uop_fields
    import tmma_pkg::*;
#(
    parameter int unsigned SET_W     = 2,
    parameter int unsigned STEP_W    = 2,
    parameter int unsigned REG_W     = 6,
    parameter int unsigned FREG_BASE = 32,
    parameter int unsigned ACC_BASE  = 16,
    parameter int unsigned SRCB_BASE = 8,
    parameter int unsigned OP_W      = 4,
    parameter int unsigned MOD_W     = 3,
    parameter int unsigned EX_W      = 3,
    parameter int unsigned EX_TENSOR = 5,
    parameter int unsigned DATA_W    = 32
) (
    input  logic [SET_W-1:0]  set_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              half_i,
    input  logic              last_i,
    output logic [EX_W-1:0]   ex_o,
    output logic [OP_W-1:0]   op_o,
    output logic [MOD_W-1:0]  mod_o,
    output uop_flags_t        flags_o,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] imm_o,
    output logic [REG_W-1:0]  rd_o,
    output logic [REG_W-1:0]  rs1_o,
    output logic [REG_W-1:0]  rs2_o,
    output logic [REG_W-1:0]  rs3_o
);

    localparam logic [REG_W-1:0] ACC_REG  = REG_W'(FREG_BASE + ACC_BASE);
    localparam logic [REG_W-1:0] SRCA_REG = REG_W'(FREG_BASE);
    localparam logic [REG_W-1:0] SRCB_REG = REG_W'(FREG_BASE + SRCB_BASE);

    logic [REG_W-1:0] acc_off;
    logic [REG_W-1:0] src_off;

    // Register offsets: the accumulator follows step, the sources follow set
    always_comb begin
        acc_off = REG_W'({step_i, half_i});
        src_off = REG_W'({set_i, half_i});
    end

    // Execution metadata and flags
    always_comb begin
        ex_o            = EX_W'(EX_TENSOR);
        op_o            = OP_W'(step_i);
        mod_o           = MOD_W'(half_i);
        flags_o.wb      = 1'b1;
        flags_o.use_pc  = 1'b0;
        flags_o.use_imm = 1'b0;
        pc_o            = last_i ? DATA_W'(1) : '0;
        imm_o           = last_i ? DATA_W'(1) : '0;
    end

    // Register indices; the accumulator is both a source and the destination
    always_comb begin
        rd_o  = ACC_REG + acc_off;
        rs3_o = ACC_REG + acc_off;
        rs1_o = SRCA_REG + src_off;
        rs2_o = SRCB_REG + src_off;
    end

endmodule

// File: rtl/tmma_seq_ctrl.sv
// Module: idle/run control for the sequencer.
// Accepts a macro only when idle, counts output handshakes while running,
// and drops back to idle on the handshake of the finish micro-op.
// Assumes: last_i reflects the micro-op currently presented.
module tmma_seq_ctrl
    import tmma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mac_valid,
    input  logic uop_ready,
    input  logic last_i,
    output logic mac_ready,
    output logic uop_valid,
    output logic accept,
    output logic fire,
    output logic done
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Handshake decode
    always_comb begin
        mac_ready = (state_q == SEQ_IDLE);
        uop_valid = (state_q == SEQ_RUN);
        accept    = mac_ready && mac_valid;
        fire      = uop_valid && uop_ready;
        done      = fire && last_i;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = SEQ_RUN;
        end else if (done) begin
            state_d = SEQ_IDLE;
        end
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/tmma_uop_seq.sv
// Module: tensor micro-op expansion sequencer (top).
// Expands one multiply-accumulate macro into 32 micro-ops on a
// valid/ready port and pulses seq_done with the finish micro-op.
// Assumes: the downstream holds or takes each micro-op by the usual
// valid/ready rule; macros are offered through mac_valid/mac_ready.
module tmma_uop_seq
    import tmma_pkg::*;
#(
    parameter int unsigned SET_W     = 2,
    parameter int unsigned STEP_W    = 2,
    parameter int unsigned REG_W     = 6,
    parameter int unsigned FREG_BASE = 32,
    parameter int unsigned ACC_BASE  = 16,
    parameter int unsigned SRCB_BASE = 8,
    parameter int unsigned OP_W      = 4,
    parameter int unsigned MOD_W     = 3,
    parameter int unsigned EX_W      = 3,
    parameter int unsigned EX_TENSOR = 5,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned IDX_W    = SET_W + STEP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_valid,
    output logic              mac_ready,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [IDX_W-1:0]  uop_seq,
    output logic [IDX_W-1:0]  uop_next,
    output logic              uop_last,
    output logic [EX_W-1:0]   uop_ex,
    output logic [OP_W-1:0]   uop_op,
    output logic [MOD_W-1:0]  uop_mod,
    output logic              uop_wb,
    output logic              uop_use_pc,
    output logic              uop_use_imm,
    output logic [DATA_W-1:0] uop_pc,
    output logic [DATA_W-1:0] uop_imm,
    output logic [REG_W-1:0]  uop_rd,
    output logic [REG_W-1:0]  uop_rs1,
    output logic [REG_W-1:0]  uop_rs2,
    output logic [REG_W-1:0]  uop_rs3,
    output logic              seq_done
);

    logic              accept;
    logic              fire;
    logic [SET_W-1:0]  cur_set;
    logic [STEP_W-1:0] cur_step;
    logic              cur_half;
    uop_flags_t        flags;

    tmma_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mac_valid (mac_valid),
        .uop_ready (uop_ready),
        .last_i    (uop_last),
        .mac_ready (mac_ready),
        .uop_valid (uop_valid),
        .accept    (accept),
        .fire      (fire),
        .done      (seq_done)
    );

    tmma_uop_counter #(
        .SET_W  (SET_W),
        .STEP_W (STEP_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (fire),
        .set_o   (cur_set),
        .step_o  (cur_step),
        .half_o  (cur_half),
        .idx_o   (uop_seq),
        .next_o  (uop_next),
        .last_o  (uop_last)
    );

    tmma_uop_fields #(
        .SET_W     (SET_W),
        .STEP_W    (STEP_W),
        .REG_W     (REG_W),
        .FREG_BASE (FREG_BASE),
        .ACC_BASE  (ACC_BASE),
        .SRCB_BASE (SRCB_BASE),
        .OP_W      (OP_W),
        .MOD_W     (MOD_W),
        .EX_W      (EX_W),
        .EX_TENSOR (EX_TENSOR),
        .DATA_W    (DATA_W)
    ) u_fields (
        .set_i   (cur_set),
        .step_i  (cur_step),
        .half_i  (cur_half),
        .last_i  (uop_last),
        .ex_o    (uop_ex),
        .op_o    (uop_op),
        .mod_o   (uop_mod),
        .flags_o (flags),
        .pc_o    (uop_pc),
        .imm_o   (uop_imm),
        .rd_o    (uop_rd),
        .rs1_o   (uop_rs1),
        .rs2_o   (uop_rs2),
        .rs3_o   (uop_rs3)
    );

    // Flag fan-out to ports
    always_comb begin
        uop_wb      = flags.wb;
        uop_use_pc  = flags.use_pc;
        uop_use_imm = flags.use_imm;
    end

endmodule

// File: rtl/tmma_uop_seq_chk.sv
// Module: assertion checker bound to the sequencer top.
// Assumes: attached through the bind at the end of this file.
module tmma_uop_seq_chk #(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned REG_W  = 6,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mac_valid,
    input logic              mac_ready,
    input logic              uop_valid,
    input logic              uop_ready,
    input logic [IDX_W-1:0]  uop_seq,
    input logic [IDX_W-1:0]  uop_next,
    input logic              uop_last,
    input logic              uop_wb,
    input logic              uop_use_pc,
    input logic              uop_use_imm,
    input logic [DATA_W-1:0] uop_pc,
    input logic [DATA_W-1:0] uop_imm,
    input logic [REG_W-1:0]  uop_rd,
    input logic [REG_W-1:0]  uop_rs1,
    input logic [REG_W-1:0]  uop_rs2,
    input logic              seq_done
);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_seq) &&
        $stable(uop_rd) && $stable(uop_rs1) && $stable(uop_rs2)));

    assert_step_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && !uop_last) |=> (uop_valid && uop_seq == $past(uop_next)));

    assert_done_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (uop_valid && uop_ready && uop_last));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !mac_ready);

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (mac_ready && !uop_valid));

    assert_flags_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> (uop_wb && !uop_use_pc && !uop_use_imm));

    assert_finish_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_last) |-> (uop_pc == DATA_W'(1) && uop_imm == DATA_W'(1)));

    assert_start_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_ready && mac_valid) |=> (uop_valid && uop_seq == '0));

endmodule

bind tmma_uop_seq tmma_uop_seq_chk #(
    .IDX_W  (IDX_W),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/tmma_uop_seq_tb.sv
// Bench: sweeps every position under several ready patterns, with and
// without mac_valid held high, plus resets taken in the middle of a stream.
module tmma_uop_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mac_valid = 1'b0;
    logic        uop_ready = 1'b0;
    logic        mac_ready, uop_valid, uop_last, uop_wb, uop_use_pc, uop_use_imm, seq_done;
    logic [4:0]  uop_seq, uop_next;
    logic [2:0]  uop_ex;
    logic [3:0]  uop_op;
    logic [2:0]  uop_mod;
    logic [31:0] uop_pc, uop_imm;
    logic [5:0]  uop_rd, uop_rs1, uop_rs2, uop_rs3;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmma_uop_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mac_valid(mac_valid), .mac_ready(mac_ready),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_seq(uop_seq),
        .uop_next(uop_next), .uop_last(uop_last), .uop_ex(uop_ex), .uop_op(uop_op),
        .uop_mod(uop_mod), .uop_wb(uop_wb), .uop_use_pc(uop_use_pc),
        .uop_use_imm(uop_use_imm), .uop_pc(uop_pc), .uop_imm(uop_imm),
        .uop_rd(uop_rd), .uop_rs1(uop_rs1), .uop_rs2(uop_rs2), .uop_rs3(uop_rs3),
        .seq_done(seq_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Idle outputs (R1, R10)
    task automatic check_idle(input string req);
        check({req, " mac_ready"}, 32'(mac_ready), 1);
        check({req, " uop_valid"}, 32'(uop_valid), 0);
        check({req, " seq_done"}, 32'(seq_done), 0);
    endtask

    // All fields of position k (R2..R7)
    task automatic check_uop(input int k, input bit rdy);
        int s, st, h;
        s = k / 8; st = (k / 2) % 4; h = k % 2;
        check("R2 valid", 32'(uop_valid), 1);
        check("R9 mac_ready busy", 32'(mac_ready), 0);
        check("R2 seq", 32'(uop_seq), 32'(k));
        check("R2 next", 32'(uop_next), 32'((k + 1) % 32));
        check("R3 ex", 32'(uop_ex), 5);
        check("R3 op", 32'(uop_op), 32'(st));
        check("R3 mod", 32'(uop_mod), 32'(h));
        check("R4 rd", 32'(uop_rd), 32'(32 + 16 + 2*st + h));
        check("R4 rs3", 32'(uop_rs3), 32'(32 + 16 + 2*st + h));
        check("R5 rs1", 32'(uop_rs1), 32'(32 + 2*s + h));
        check("R5 rs2", 32'(uop_rs2), 32'(32 + 8 + 2*s + h));
        check("R6 flags", 32'({uop_wb, uop_use_pc, uop_use_imm}), 32'b100);
        check("R7 last", 32'(uop_last), 32'(k == 31));
        check("R7 pc", uop_pc, 32'(k == 31));
        check("R7 imm", uop_imm, 32'(k == 31));
        check("R9 done", 32'(seq_done), 32'(rdy && k == 31));
    endtask

    function automatic bit ready_pat(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return (cyc % 3) != 1;
            2: return ((cyc * 7 + 3) % 5) < 2;
            default: return (cyc % 2) == 1;
        endcase
    endfunction

    // Issue one macro and follow the full stream; R8 stalls keep expected k
    task automatic run_macro(input int mode, input bit hold_valid, input int stop_at);
        int k;
        int cyc;
        bit rdy;
        @(negedge clk);
        mac_valid = 1'b1; uop_ready = 1'b0;
        #1 check("R10 accept ready", 32'(mac_ready), 1);
        check("R10 idle valid", 32'(uop_valid), 0);
        @(negedge clk);
        mac_valid = hold_valid;
        k = 0; cyc = 0;
        while (k < 32 && k != stop_at) begin
            rdy = ready_pat(mode, cyc);
            uop_ready = rdy;
            #1 check_uop(k, rdy);
            if (rdy) k++;
            cyc++;
            @(negedge clk);
        end
        mac_valid = 1'b0; uop_ready = 1'b0;
        if (stop_at < 0) begin
            #1 check_idle("R10 after done");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mac_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1 check_idle("R1 reset");
        rst_n = 1'b1;
        mac_valid = 1'b0;
        @(negedge clk);
        #1 check_idle("R1 idle");
        // R2..R8 across ready patterns
        for (int m = 0; m < 4; m++) run_macro(m, 1'b0, -1);
        // R9: mac_valid held high through the stream has no effect
        run_macro(1, 1'b1, -1);
        run_macro(0, 1'b1, -1);
        // R1: reset in the middle of a stream
        run_macro(2, 1'b0, 13);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check_idle("R1 mid reset");
        run_macro(0, 1'b0, -1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule